// File: doc/BRIEF.md
# Codec Serial Control and Data Port

This block is the slave-side synchronous serial port of a mono audio codec. An external controller supplies a bit clock (`dclk`) and a frame-sync strobe (`dfs`). Each frame-sync pulse opens one 16-bit slot. The slot's data is carried most significant bit first on `din`, and at the same time on `dout`. In the default mixed mode, slots alternate between two kinds. In a control slot the incoming word is a register command, and the outgoing word is a status word that carries the answer to the previous read. In an audio slot the incoming word goes to the DAC path, and the outgoing word is the current ADC sample.

Control words address a file of seven 10-bit configuration registers. Address 5 is a read-only view of a status value that the codec core supplies. Address 3 holds the port mode. Clearing its mixed-mode bit switches the port, for good, into data mode. In data mode every slot is an audio slot and no command is decoded. Only a reset brings mixed mode back. The reset value of address 3 depends on the level of `din` while reset is held.

Top module: `codec_serial_port`

## Requirements
- R1: While `rstN` is low, `din` is sampled on each falling `dclk` edge. After reset, every register reads 0, except address 3, which reads 0x009 if `din` was low at the last reset edge and 0x008 if it was high. Bit 3 of that register is the mixed-mode bit and bit 0 is the master bit. `dout` is low.
- R2: A slot starts on the falling edge where `dfs` is sampled high, and that edge also captures bit 15 of the incoming word. The following 15 falling edges capture bits 14 down to 0. Bit 15−i of the outgoing word is driven on the rising edge after capture edge i, so the host reads it on the next falling edge. `dout` is low whenever no slot is shifting out.
- R3: In mixed mode, the first slot after reset is a control slot. After that, control slots and audio slots alternate. A control slot never produces a DAC strobe.
- R4: A control word with bit 15 = 1 writes bits 9..0 to the register selected by bits 14..11 (addresses 0, 1, 2, 3, 4 and 6). Bit 10 is ignored.
- R5: A control word with bit 15 = 0 requests a read and its data field is ignored. The next control slot returns `{0, address[3:0], 0, value[9:0]}` on `dout`, taking the value at the start of that slot. A status word that has no pending read is all zero.
- R6: Address 5 reads `statusIn`, and writes to it are discarded.
- R7: Writes to addresses 7..15 change nothing. Reads from them return a zero data field with the address echoed.
- R8: When an audio slot completes, its 16-bit word appears on `dacWord` together with a one-cycle `dacStrobe`, starting at the falling edge that captured bit 0.
- R9: An audio slot shifts out the value of `adcSample` that was present at its frame-sync edge.
- R10: Writing address 3 with bit 3 = 0 enters data mode. After that, every slot is an audio slot and the registers cannot change. Only a reset restores mixed mode.
- R11: A frame-sync pulse in the middle of a word drops the partial word and restarts the bit count. The restarted slot keeps the kind of the slot it replaces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Serial bit clock |
| rstN | input | 1 | Active-low reset, sampled on falling dclk |
| dfs | input | 1 | Frame sync, marks the first bit of a slot |
| din | input | 1 | Serial data in; its level during reset sets the mode register |
| statusIn | input | 10 | Value shown at read-only address 5 |
| adcSample | input | 16 | ADC word to send in audio slots |
| dout | output | 1 | Serial data out |
| dacWord | output | 16 | Last received audio word |
| dacStrobe | output | 1 | One-cycle pulse when dacWord is updated |
| cfgFlat | output | 70 | Register file contents, address g at bits g*10+9..g*10 |

## Verification
The hardest situations to reach are a frame-sync that lands in the middle of a word and the one-way entry into data mode. The bench cuts a control slot short after seven bits and immediately starts a full slot. It then confirms that the write in the restarted word takes effect and that the next slot is still treated as audio. After the port enters data mode, the bench sends words that look like register writes. It checks that each one reaches `dacWord` and leaves `cfgFlat` unchanged, and that only a reset returns the port to mixed mode. Reads sweep all sixteen addresses, with each answer checked one frame later.

// File: rtl/csp_pkg.sv
package csp_pkg;

  // Per-edge strobes from the slot control to the datapath.
  typedef struct packed {
    logic slotStart;  // dfs seen on this falling edge
    logic ctrlSlot;   // current (or just opened) slot is a control slot
    logic shiftRx;    // shift din into the receive register
    logic wordDone;   // this edge captures the last bit of a word
    logic shiftTx;    // advance the transmit register
    logic txActive;   // a transmit word is still being shifted out
  } csp_strobe_t;

endpackage

// File: rtl/csp_ctrl.sv
module csp_ctrl
  import csp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic        dclk,
  input  logic        rstN,
  input  logic        dfs,
  input  logic        dataMode,
  output csp_strobe_t stb
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic [CNT_W-1:0] rxCnt;
  logic [CNT_W-1:0] txCnt;
  logic             curCtrl;
  logic             expectCtrl;
  logic             midWord;
  logic             slotKind;

  always_comb begin
    midWord  = (rxCnt != '0);
    // a restart keeps the interrupted slot's kind; data mode forces audio
    slotKind = dataMode ? 1'b0 : (midWord ? curCtrl : expectCtrl);

    stb.slotStart = dfs;
    stb.ctrlSlot  = dfs ? slotKind : curCtrl;
    stb.shiftRx   = !dfs && midWord;
    stb.wordDone  = !dfs && (rxCnt == LAST_BIT);
    stb.shiftTx   = !dfs && (txCnt != '0);
    stb.txActive  = (txCnt != '0);
  end

  always_ff @(negedge dclk) begin
    if (!rstN) begin
      rxCnt      <= '0;
      txCnt      <= '0;
      curCtrl    <= 1'b0;
      expectCtrl <= 1'b1;
    end else if (dfs) begin
      rxCnt   <= CNT_W'(1);
      txCnt   <= FULL_CNT;
      curCtrl <= slotKind;
      if (!midWord) begin
        expectCtrl <= dataMode ? 1'b1 : ~expectCtrl;
      end
    end else begin
      if (midWord) begin
        rxCnt <= (rxCnt == LAST_BIT) ? '0 : rxCnt + 1'b1;
      end
      if (txCnt != '0) begin
        txCnt <= txCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/csp_datapath.sv
module csp_datapath
  import csp_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int REG_W      = 10,
  parameter int ADDR_W     = 4,
  parameter int NUM_REGS   = 7,
  parameter int RO_ADDR    = 5,
  parameter int MODE_ADDR  = 3,
  parameter int MIXED_BIT  = 3,
  parameter int MASTER_BIT = 0
) (
  input  logic                      dclk,
  input  logic                      rstN,
  input  logic                      din,
  input  csp_strobe_t               stb,
  input  logic [REG_W-1:0]          statusIn,
  input  logic [WORD_W-1:0]         adcSample,
  output logic                      dataMode,
  output logic [NUM_REGS*REG_W-1:0] cfgFlat,
  output logic [WORD_W-1:0]         dacWord,
  output logic                      dacStrobe,
  output logic                      dout
);

  localparam int ADDR_LSB = REG_W + 1;
  localparam int RW_BIT   = WORD_W - 1;
  localparam logic [REG_W-1:0] MIXED_MASK  = REG_W'(1) << MIXED_BIT;
  localparam logic [REG_W-1:0] MASTER_MASK = REG_W'(1) << MASTER_BIT;

  logic [WORD_W-2:0] rxShift;
  logic [WORD_W-1:0] fullWord;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] statusWord;
  logic              isWrite;
  logic [ADDR_W-1:0] wordAddr;
  logic [REG_W-1:0]  wordData;
  logic              ctrlDone;
  logic              dacDone;
  logic [REG_W-1:0]  modeRst;
  logic              rdPend;
  logic [ADDR_W-1:0] rdAddr;
  logic [REG_W-1:0]  readVal;
  logic [REG_W-1:0]  regView [NUM_REGS];

  // ---------------- receive side ----------------
  always_ff @(negedge dclk) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (stb.slotStart) begin
      rxShift <= {{(WORD_W-2){1'b0}}, din};
    end else if (stb.shiftRx) begin
      rxShift <= {rxShift[WORD_W-3:0], din};
    end
  end

  always_comb begin
    fullWord = {rxShift, din};
    isWrite  = fullWord[RW_BIT];
    wordAddr = fullWord[ADDR_LSB +: ADDR_W];
    wordData = fullWord[REG_W-1:0];
    ctrlDone = stb.wordDone && stb.ctrlSlot;
    dacDone  = stb.wordDone && !stb.ctrlSlot;
    modeRst  = MIXED_MASK | (din ? '0 : MASTER_MASK);
  end

  // ---------------- register file ----------------
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == RO_ADDR) begin : g_ro
      assign regView[g] = statusIn;
    end else begin : g_rw
      logic [REG_W-1:0] q;
      always_ff @(negedge dclk) begin
        if (!rstN) begin
          q <= (g == MODE_ADDR) ? modeRst : '0;
        end else if (ctrlDone && isWrite && (wordAddr == ADDR_W'(g))) begin
          q <= wordData;
        end
      end
      assign regView[g] = q;
    end
    assign cfgFlat[g*REG_W +: REG_W] = regView[g];
  end

  assign dataMode = ~regView[MODE_ADDR][MIXED_BIT];

  // ---------------- delayed read ----------------
  always_ff @(negedge dclk) begin
    if (!rstN) begin
      rdPend <= 1'b0;
      rdAddr <= '0;
    end else if (ctrlDone) begin
      rdPend <= ~isWrite;
      rdAddr <= wordAddr;
    end
  end

  always_comb begin
    readVal = '0;
    for (int g = 0; g < NUM_REGS; g++) begin
      if (rdAddr == ADDR_W'(g)) begin
        readVal = regView[g];
      end
    end
    statusWord = rdPend ? WORD_W'({1'b0, rdAddr, 1'b0, readVal}) : '0;
  end

  // ---------------- audio output ----------------
  always_ff @(negedge dclk) begin
    if (!rstN) begin
      dacWord   <= '0;
      dacStrobe <= 1'b0;
    end else begin
      dacStrobe <= dacDone;
      if (dacDone) begin
        dacWord <= fullWord;
      end
    end
  end

  // ---------------- transmit side ----------------
  always_ff @(negedge dclk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (stb.slotStart) begin
      txShift <= stb.ctrlSlot ? statusWord : adcSample;
    end else if (stb.shiftTx) begin
      txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge dclk) begin
    if (!rstN) begin
      dout <= 1'b0;
    end else begin
      dout <= stb.txActive & txShift[WORD_W-1];
    end
  end

endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import csp_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int REG_W      = 10,
  parameter int ADDR_W     = 4,
  parameter int NUM_REGS   = 7,
  parameter int RO_ADDR    = 5,
  parameter int MODE_ADDR  = 3,
  parameter int MIXED_BIT  = 3,
  parameter int MASTER_BIT = 0
) (
  input  logic                      dclk,
  input  logic                      rstN,
  input  logic                      dfs,
  input  logic                      din,
  input  logic [REG_W-1:0]          statusIn,
  input  logic [WORD_W-1:0]         adcSample,
  output logic                      dout,
  output logic [WORD_W-1:0]         dacWord,
  output logic                      dacStrobe,
  output logic [NUM_REGS*REG_W-1:0] cfgFlat
);

  csp_strobe_t stb;
  logic        dataMode;

  csp_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .dclk    (dclk),
    .rstN    (rstN),
    .dfs     (dfs),
    .dataMode(dataMode),
    .stb     (stb)
  );

  csp_datapath #(
    .WORD_W    (WORD_W),
    .REG_W     (REG_W),
    .ADDR_W    (ADDR_W),
    .NUM_REGS  (NUM_REGS),
    .RO_ADDR   (RO_ADDR),
    .MODE_ADDR (MODE_ADDR),
    .MIXED_BIT (MIXED_BIT),
    .MASTER_BIT(MASTER_BIT)
  ) u_dp (
    .dclk     (dclk),
    .rstN     (rstN),
    .din      (din),
    .stb      (stb),
    .statusIn (statusIn),
    .adcSample(adcSample),
    .dataMode (dataMode),
    .cfgFlat  (cfgFlat),
    .dacWord  (dacWord),
    .dacStrobe(dacStrobe),
    .dout     (dout)
  );

endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
  parameter int REG_W     = 10,
  parameter int NUM_REGS  = 7,
  parameter int RO_ADDR   = 5,
  parameter int MODE_ADDR = 3,
  parameter int MIXED_BIT = 3
) (
  input logic                      dclk,
  input logic                      rstN,
  input logic                      dfs,
  input logic                      dacStrobe,
  input logic [NUM_REGS*REG_W-1:0] cfgFlat
);

  logic                      modeBit;
  logic [NUM_REGS*REG_W-1:0] cfgMasked;

  always_comb begin
    modeBit   = cfgFlat[MODE_ADDR*REG_W + MIXED_BIT];
    cfgMasked = cfgFlat;
    cfgMasked[RO_ADDR*REG_W +: REG_W] = '0;
  end

  // R10: data mode is never left without reset
  a_r10_data_mode_sticky: assert property (@(negedge dclk) disable iff (!rstN)
    !modeBit |=> !modeBit)
    else $error("data mode left without reset");

  // R10: writable registers frozen in data mode
  a_r10_regs_frozen: assert property (@(negedge dclk) disable iff (!rstN)
    !modeBit |=> $stable(cfgMasked))
    else $error("register changed in data mode");

  // R8: DAC strobe lasts one cycle
  a_r8_strobe_single: assert property (@(negedge dclk) disable iff (!rstN)
    dacStrobe |=> !dacStrobe)
    else $error("dac strobe longer than one cycle");

  // R11: a word completes only on an edge without frame sync
  a_r11_done_without_dfs: assert property (@(negedge dclk) disable iff (!rstN)
    dacStrobe |-> !$past(dfs))
    else $error("word completed on a frame-sync edge");

endmodule

bind codec_serial_port csp_checker #(
  .REG_W    (REG_W),
  .NUM_REGS (NUM_REGS),
  .RO_ADDR  (RO_ADDR),
  .MODE_ADDR(MODE_ADDR),
  .MIXED_BIT(MIXED_BIT)
) u_chk (
  .dclk     (dclk),
  .rstN     (rstN),
  .dfs      (dfs),
  .dacStrobe(dacStrobe),
  .cfgFlat  (cfgFlat)
);

// File: tb/codec_serial_port_tb.sv
module codec_serial_port_tb;

  localparam int CLK_PERIOD = 10;

  logic        dclk = 1'b0;
  logic        rstN;
  logic        dfs;
  logic        din;
  logic [9:0]  statusIn;
  logic [15:0] adcSample;
  logic        dout;
  logic [15:0] dacWord;
  logic        dacStrobe;
  logic [69:0] cfgFlat;

  int  nChecks = 0;
  int  nBad    = 0;
  bit  finished = 1'b0;

  logic        lastStrobe;
  logic [15:0] lastDac;
  logic [9:0]  expReg [7];

  always #(CLK_PERIOD/2) dclk = ~dclk;

  codec_serial_port u_dut (
    .dclk(dclk), .rstN(rstN), .dfs(dfs), .din(din),
    .statusIn(statusIn), .adcSample(adcSample), .dout(dout),
    .dacWord(dacWord), .dacStrobe(dacStrobe), .cfgFlat(cfgFlat)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wordWr(input int a, input logic [9:0] d);
    return {1'b1, 4'(a), 1'b0, d};
  endfunction

  function automatic logic [15:0] wordRd(input int a);
    return {1'b0, 4'(a), 1'b0, 10'h3FF};
  endfunction

  function automatic logic [9:0] pat(input int a);
    return 10'((a * 157 + 29) & 1023) | ((a == 3) ? 10'h008 : 10'h000);
  endfunction

  function automatic logic [9:0] cfgAt(input int g);
    return cfgFlat[g*10 +: 10];
  endfunction

  function automatic logic [9:0] expVal(input int a);
    if (a == 5) return statusIn;
    if (a < 7) return expReg[a];
    return 10'h000;
  endfunction

  task automatic doReset(input logic dinLvl);
    @(posedge dclk); #1;
    rstN = 1'b0; dfs = 1'b0; din = dinLvl;
    repeat (4) @(posedge dclk);
    #1;
    rstN = 1'b1; din = 1'b0;
  endtask

  // one full slot: drive w on din, collect 16 dout bits, note dac strobe
  task automatic xferWord(input logic [15:0] w, output logic [15:0] rx);
    rx = '0;
    for (int i = 0; i < 16; i++) begin
      @(posedge dclk); #1;
      if (i > 0) rx[16-i] = dout;
      dfs = (i == 0);
      din = w[15-i];
    end
    @(posedge dclk); #1;
    rx[0]      = dout;
    lastStrobe = dacStrobe;
    lastDac    = dacWord;
    dfs = 1'b0;
    din = 1'b0;
  endtask

  task automatic partialWord(input int n, input logic [15:0] w);
    for (int i = 0; i < n; i++) begin
      @(posedge dclk); #1;
      dfs = (i == 0);
      din = w[15-i];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] st;
    logic [15:0] ao;
    logic [15:0] dacW;
    logic [15:0] expSt;

    rstN = 1'b0; dfs = 1'b0; din = 1'b0;
    statusIn = 10'h000; adcSample = 16'h0000;

    // R1: reset with din low, then high
    doReset(1'b0);
    @(posedge dclk); #1;
    chk(cfgAt(3) == 10'h009, "R1 mode reg din low", 32'(cfgAt(3)), 32'h009);
    for (int g = 0; g < 7; g++) begin
      if (g != 3) chk(cfgAt(g) == 10'h000, "R1 reg zero", 32'(cfgAt(g)), 32'h0);
    end
    chk(dout == 1'b0, "R1 dout low", 32'(dout), 32'h0);
    doReset(1'b1);
    @(posedge dclk); #1;
    chk(cfgAt(3) == 10'h008, "R1 mode reg din high", 32'(cfgAt(3)), 32'h008);
    doReset(1'b0);
    for (int g = 0; g < 7; g++) expReg[g] = 10'h000;
    expReg[3] = 10'h009;

    // R3 R4 R6 R7 R8 R9: write sweep over all addresses
    for (int a = 0; a < 16; a++) begin
      dacW      = 16'(32'hC001 + a * 32'h0531);
      adcSample = 16'(32'h1357 + a * 32'h2468);
      xferWord(wordWr(a, pat(a)), st);
      chk(!lastStrobe, "R3 no dac strobe in control slot", 32'(lastStrobe), 32'h0);
      chk(st == 16'h0000, "R5 empty status", 32'(st), 32'h0);
      xferWord(dacW, ao);
      chk(lastStrobe && lastDac == dacW, "R8 dac word", 32'(lastDac), 32'(dacW));
      chk(ao == adcSample, "R9 adc word", 32'(ao), 32'(adcSample));
      if (a < 7 && a != 5) expReg[a] = pat(a);
    end
    statusIn = 10'h2A5;
    @(negedge dclk); #1;
    for (int g = 0; g < 7; g++) begin
      chk(cfgAt(g) == expVal(g), (g == 5) ? "R6 read-only view" : "R4 written value",
          32'(cfgAt(g)), 32'(expVal(g)));
    end

    // R5 R6 R7: read sweep, answers one frame later
    for (int a = 0; a <= 16; a++) begin
      xferWord((a < 16) ? wordRd(a) : wordWr(6, expReg[6]), st);
      if (a > 0) begin
        expSt = {1'b0, 4'(a - 1), 1'b0, expVal(a - 1)};
        chk(st == expSt, (a - 1 >= 7) ? "R7 unused read" : ((a - 1 == 5) ? "R6 read" : "R5 read"),
            32'(st), 32'(expSt));
      end
      xferWord(16'h0000, ao);
    end
    xferWord(16'h0000 | wordRd(0) & 16'h0000 | wordWr(7, 10'h3FF), st);
    chk(st == 16'h0000, "R5 no pending read", 32'(st), 32'h0);
    xferWord(16'hAAAA, ao);

    // R2: dout idle between slots
    @(posedge dclk); #1;
    chk(dout == 1'b0, "R2 dout idle", 32'(dout), 32'h0);

    // R11: restart in the middle of a control word
    partialWord(7, 16'hFFFF);
    xferWord(wordWr(0, 10'h155), st);
    xferWord(16'h1234, ao);
    chk(lastStrobe && lastDac == 16'h1234, "R11 restarted slot kept kind", 32'(lastDac), 32'h1234);
    chk(cfgAt(0) == 10'h155, "R11 restarted write", 32'(cfgAt(0)), 32'h155);
    expReg[0] = 10'h155;

    // R10: enter data mode, command-looking words go to the DAC
    xferWord(wordWr(3, 10'h000), st);
    xferWord(16'h0F0F, ao);
    chk(cfgAt(3) == 10'h000, "R10 mode written", 32'(cfgAt(3)), 32'h0);
    for (int k = 0; k < 4; k++) begin
      adcSample = 16'(32'h8421 + k * 32'h1111);
      xferWord(wordWr(0, 10'h3C3), ao);
      chk(lastStrobe && lastDac == wordWr(0, 10'h3C3), "R10 slot is audio",
          32'(lastDac), 32'(wordWr(0, 10'h3C3)));
      chk(ao == adcSample, "R10 adc out", 32'(ao), 32'(adcSample));
      chk(cfgAt(0) == 10'h155, "R10 regs frozen", 32'(cfgAt(0)), 32'h155);
      chk(cfgAt(3) == 10'h000, "R10 mode kept", 32'(cfgAt(3)), 32'h0);
    end
    doReset(1'b0);
    @(posedge dclk); #1;
    chk(cfgAt(3) == 10'h009, "R10 reset restores mixed", 32'(cfgAt(3)), 32'h009);
    xferWord(wordWr(0, 10'h0AA), st);
    xferWord(16'h7777, ao);
    chk(cfgAt(0) == 10'h0AA, "R10 control decoded again", 32'(cfgAt(0)), 32'h0AA);
    chk(lastStrobe && lastDac == 16'h7777, "R3 alternation after reset", 32'(lastDac), 32'h7777);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule